// File: doc/BRIEF.md
# RMII Receive Path Decoder (MAC side)

This block sits on the MAC side of a reduced media independent interface. Every cycle of the reference clock it takes in the two-bit receive data, the shared carrier-sense/data-valid line and the receive error line. From the one multiplexed line it rebuilds two separate signals: a carrier indication and a receive-data-valid indication. To do this it reads the nibble-aligned pattern that the PHY produces when carrier is lost while data is still draining: the line is low on the first di-bit of each nibble and high on the second.

Received di-bits are scanned for the preamble and the start delimiter. After the delimiter they are packed into bytes, and the bytes come out as a registered stream. Each byte carries a start-of-frame flag, an end-of-frame flag, an error flag and an alignment error flag. The `mode_10m` input picks between one di-bit per clock and one di-bit per ten clocks. In the slow rate the line is sampled once, in the middle of each hold period.

Top module: `rmii_rx_decoder`

## Requirements
- R1: While `rst` is high, at each clock edge every output returns to zero.
- R2: With `mode_10m` low, one di-bit is taken per clock. With it high, the block counts from the first registered cycle in which the line is high. It then takes the registered value of the fifth cycle of every ten-cycle hold period, and values in the other nine cycles have no effect on any output.
- R3: `carrier_o` and `rx_dv_o` rise together. In fast mode this happens one edge after the edge that registers the first high sample of the carrier line. In slow mode it happens five edges after the edge that registers the first cycle of the first hold period.
- R4: Nibble positions are counted from the first di-bit of the frame. `carrier_o` falls at the first first-position di-bit on which the carrier line is low, with the R3 latency. Later highs on the line within the same frame do not raise it again.
- R5: `rx_dv_o` stays high through the toggling pattern. It falls, with the R3 latency, on the second di-bit of the first nibble in which the carrier line is low on both di-bits. That nibble carries no data.
- R6: Di-bits are discarded until the value 01 is immediately followed by 11. The di-bit after the 11 is the first data di-bit.
- R7: Four data di-bits make one byte. The first di-bit goes to bits 1:0 and the fourth to bits 7:6. Bytes come out in arrival order, each as a one-cycle `byte_vld_o` pulse, never on two adjacent cycles.
- R8: `sof_o` marks the first byte of a frame. `eof_o` marks the last complete byte and is issued after data valid ends, because each byte is held back until the next one completes or the frame ends.
- R9: `byte_err_o` is high on a byte when the receive error line was sampled high with any of its four di-bits.
- R10: Leftover data di-bits (one to three) at the end of a frame are discarded, and `align_err_o` is raised together with `eof_o`. A frame with no complete byte, or with no start delimiter, produces no byte at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_10m | input | 1 | 1 = slow rate (one di-bit per RATIO_10M clocks), 0 = fast rate |
| rmii_rxd | input | 2 | Receive di-bit |
| rmii_crs_dv | input | 1 | Multiplexed carrier sense / data valid |
| rmii_rx_er | input | 1 | Receive error from the PHY |
| carrier_o | output | 1 | Recovered carrier sense |
| rx_dv_o | output | 1 | Recovered receive data valid |
| byte_o | output | DATA_W | Received byte |
| byte_vld_o | output | 1 | One-cycle strobe for `byte_o` |
| sof_o | output | 1 | First byte of a frame |
| eof_o | output | 1 | Last complete byte of a frame |
| byte_err_o | output | 1 | Receive error seen during this byte |
| align_err_o | output | 1 | Frame ended with a partial byte |

## Verification
The bench varies how many nibbles of toggling follow the loss of carrier, including none. A decoder that drops data valid on the first low sample would lose the tail bytes and move the valid edge. One that ignores nibble phase would move the carrier edge. The start delimiter is placed on both the first and the second di-bit of a nibble, and frames end with zero to three spare di-bits, so that misaligned packing, a missing alignment flag or a premature end marker all show up as wrong bytes or wrong flags. In slow mode the bench drives inverted data and error values on every cycle outside the middle of the hold period, so a sampler with the wrong phase delivers corrupted bytes. Frames without a delimiter, and frames holding only a partial byte, must produce nothing.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  localparam int PAIR_W = 2;

  // Hunt pattern: a preamble di-bit followed directly by the delimiter di-bit
  localparam logic [PAIR_W-1:0] PRE_PAIR = 2'b01;
  localparam logic [PAIR_W-1:0] SFD_PAIR = 2'b11;

  // One nibble worth of receive data: earlier di-bit in lo, later in hi
  typedef struct packed {
    logic [PAIR_W-1:0] hi;
    logic              hi_er;
    logic [PAIR_W-1:0] lo;
    logic              lo_er;
  } beat_t;

endpackage

// File: rtl/rmii_rx_strobe.sv
module rmii_rx_strobe
  import rmii_rx_pkg::*;
#(
  parameter int RATIO = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_10m,
  input  logic [PAIR_W-1:0] rxd_i,
  input  logic              crsdv_i,
  input  logic              er_i,
  input  logic              frame_done,
  output logic              smp_stb,
  output logic [PAIR_W-1:0] smp_rxd,
  output logic              smp_crsdv,
  output logic              smp_er
);

  localparam int CNT_W = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [CNT_W-1:0] MID_IDX  = CNT_W'(RATIO / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(RATIO - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] idx;

  // Input capture stage
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_rxd   <= '0;
      smp_crsdv <= 1'b0;
      smp_er    <= 1'b0;
    end else begin
      smp_rxd   <= rxd_i;
      smp_crsdv <= crsdv_i;
      smp_er    <= er_i;
    end
  end

  // Position inside the slow-rate hold period, anchored on the first high sample
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (frame_done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (smp_crsdv) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(1);
      end
    end else begin
      cnt <= (cnt == LAST_IDX) ? '0 : cnt + CNT_W'(1);
    end
  end

  always_comb begin
    idx = busy ? cnt : '0;
    if (mode_10m) smp_stb = (busy || smp_crsdv) && (idx == MID_IDX);
    else          smp_stb = 1'b1;
  end

  // R2
  one_sample_per_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_10m && smp_stb) |=> !smp_stb);

endmodule

// File: rtl/rmii_rx_carrier.sv
module rmii_rx_carrier
  import rmii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [PAIR_W-1:0] rxd,
  input  logic              crsdv,
  input  logic              er,
  output logic              crs_o,
  output logic              dv_o,
  output beat_t             beat_o,
  output logic              beat_vld,
  output logic              dv_end
);

  logic              second;   // next sample is the second di-bit of a nibble
  logic [PAIR_W-1:0] p0_d;
  logic              p0_c;
  logic              p0_er;

  always_ff @(posedge clk) begin
    if (rst) begin
      crs_o    <= 1'b0;
      dv_o     <= 1'b0;
      second   <= 1'b0;
      p0_d     <= '0;
      p0_c     <= 1'b0;
      p0_er    <= 1'b0;
      beat_o   <= '0;
      beat_vld <= 1'b0;
      dv_end   <= 1'b0;
    end else begin
      beat_vld <= 1'b0;
      dv_end   <= 1'b0;
      if (stb) begin
        if (!dv_o) begin
          if (crsdv) begin
            dv_o   <= 1'b1;
            crs_o  <= 1'b1;
            second <= 1'b1;
            p0_d   <= rxd;
            p0_c   <= 1'b1;
            p0_er  <= er;
          end
        end else if (!second) begin
          p0_d   <= rxd;
          p0_c   <= crsdv;
          p0_er  <= er;
          second <= 1'b1;
          if (!crsdv) crs_o <= 1'b0;
        end else begin
          second <= 1'b0;
          if (p0_c || crsdv) begin
            beat_vld <= 1'b1;
            beat_o   <= '{hi: rxd, hi_er: er, lo: p0_d, lo_er: p0_er};
          end else begin
            dv_end <= 1'b1;
            dv_o   <= 1'b0;
            crs_o  <= 1'b0;
          end
        end
      end
    end
  end

  // R3
  rise_together_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dv_o) |-> crs_o);

  // R4
  carrier_within_valid_chk: assert property (@(posedge clk) disable iff (rst)
    crs_o |-> dv_o);

endmodule

// File: rtl/rmii_rx_framer.sv
module rmii_rx_framer
  import rmii_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  beat_t             beat,
  input  logic              beat_vld,
  input  logic              dv_end,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_err,
  output logic              out_align
);

  localparam int PPB  = DATA_W / PAIR_W;
  localparam int PC_W = (PPB > 2) ? $clog2(PPB) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PPB - 1);

  // Frame assembly state
  logic              in_data;
  logic              seen_pre;
  logic [DATA_W-1:0] acc;
  logic [PC_W-1:0]   pcnt;
  logic              acc_er;
  logic              first;

  // One-byte holding slot so the final byte can be tagged
  logic              hold_v;
  logic [DATA_W-1:0] hold_d;
  logic              hold_sof;
  logic              hold_er;

  // Next-state of the assembly after both di-bits of a beat
  logic              n_data;
  logic              n_seen;
  logic [DATA_W-1:0] n_acc;
  logic [PC_W-1:0]   n_pcnt;
  logic              n_er;
  logic              done;
  logic [DATA_W-1:0] done_d;
  logic              done_er;
  logic [PAIR_W-1:0] pd;
  logic              pe;

  always_comb begin
    n_data  = in_data;
    n_seen  = seen_pre;
    n_acc   = acc;
    n_pcnt  = pcnt;
    n_er    = acc_er;
    done    = 1'b0;
    done_d  = '0;
    done_er = 1'b0;
    pd      = '0;
    pe      = 1'b0;
    for (int k = 0; k < 2; k++) begin
      pd = (k == 0) ? beat.lo : beat.hi;
      pe = (k == 0) ? beat.lo_er : beat.hi_er;
      if (!n_data) begin
        if (n_seen && pd == SFD_PAIR) begin
          n_data = 1'b1;
          n_seen = 1'b0;
        end else begin
          n_seen = (pd == PRE_PAIR);
        end
      end else begin
        n_acc[int'(n_pcnt)*PAIR_W +: PAIR_W] = pd;
        n_er = n_er | pe;
        if (n_pcnt == PC_LAST) begin
          done    = 1'b1;
          done_d  = n_acc;
          done_er = n_er;
          n_pcnt  = '0;
          n_er    = 1'b0;
        end else begin
          n_pcnt = n_pcnt + PC_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_data   <= 1'b0;
      seen_pre  <= 1'b0;
      acc       <= '0;
      pcnt      <= '0;
      acc_er    <= 1'b0;
      first     <= 1'b1;
      hold_v    <= 1'b0;
      hold_d    <= '0;
      hold_sof  <= 1'b0;
      hold_er   <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_err   <= 1'b0;
      out_align <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_err   <= 1'b0;
      out_align <= 1'b0;
      if (dv_end) begin
        if (hold_v) begin
          out_valid <= 1'b1;
          out_data  <= hold_d;
          out_sof   <= hold_sof;
          out_err   <= hold_er;
          out_eof   <= 1'b1;
          out_align <= (pcnt != '0);
        end
        in_data  <= 1'b0;
        seen_pre <= 1'b0;
        pcnt     <= '0;
        acc_er   <= 1'b0;
        hold_v   <= 1'b0;
        first    <= 1'b1;
      end else if (beat_vld) begin
        in_data  <= n_data;
        seen_pre <= n_seen;
        acc      <= n_acc;
        pcnt     <= n_pcnt;
        acc_er   <= n_er;
        if (done) begin
          if (hold_v) begin
            out_valid <= 1'b1;
            out_data  <= hold_d;
            out_sof   <= hold_sof;
            out_err   <= hold_er;
          end
          hold_v   <= 1'b1;
          hold_d   <= done_d;
          hold_sof <= first;
          hold_er  <= done_er;
          first    <= 1'b0;
        end
      end
    end
  end

  // R7
  spaced_bytes_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R8
  sof_with_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (out_sof || out_eof) |-> out_valid);

  // R10
  align_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    out_align |-> out_eof);

endmodule

// File: rtl/rmii_rx_decoder.sv
module rmii_rx_decoder
  import rmii_rx_pkg::*;
#(
  parameter int RATIO_10M = 10,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_10m,
  input  logic [PAIR_W-1:0] rmii_rxd,
  input  logic              rmii_crs_dv,
  input  logic              rmii_rx_er,
  output logic              carrier_o,
  output logic              rx_dv_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              byte_err_o,
  output logic              align_err_o
);

  logic              stb;
  logic [PAIR_W-1:0] s_rxd;
  logic              s_crsdv;
  logic              s_er;
  beat_t             beat;
  logic              beat_vld;
  logic              dv_end;

  rmii_rx_strobe #(.RATIO(RATIO_10M)) u_strobe (
    .clk        (clk),
    .rst        (rst),
    .mode_10m   (mode_10m),
    .rxd_i      (rmii_rxd),
    .crsdv_i    (rmii_crs_dv),
    .er_i       (rmii_rx_er),
    .frame_done (dv_end),
    .smp_stb    (stb),
    .smp_rxd    (s_rxd),
    .smp_crsdv  (s_crsdv),
    .smp_er     (s_er)
  );

  rmii_rx_carrier u_carrier (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .rxd      (s_rxd),
    .crsdv    (s_crsdv),
    .er       (s_er),
    .crs_o    (carrier_o),
    .dv_o     (rx_dv_o),
    .beat_o   (beat),
    .beat_vld (beat_vld),
    .dv_end   (dv_end)
  );

  rmii_rx_framer #(.DATA_W(DATA_W)) u_framer (
    .clk       (clk),
    .rst       (rst),
    .beat      (beat),
    .beat_vld  (beat_vld),
    .dv_end    (dv_end),
    .out_data  (byte_o),
    .out_valid (byte_vld_o),
    .out_sof   (sof_o),
    .out_eof   (eof_o),
    .out_err   (byte_err_o),
    .out_align (align_err_o)
  );

endmodule

// File: tb/sim_rmii_rx_decoder.sv
module sim_rmii_rx_decoder;

  localparam int RATIO = 10;
  localparam int DW    = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          mode_10m = 1'b0;
  logic [1:0]    rxd = 2'b00;
  logic          crs_dv = 1'b0;
  logic          rx_er = 1'b0;
  logic          carrier, rxdv, bvld, bsof, beof, berr, balign;
  logic [DW-1:0] bdata;

  rmii_rx_decoder #(.RATIO_10M(RATIO), .DATA_W(DW)) u0 (
    .clk         (clk),
    .rst         (rst),
    .mode_10m    (mode_10m),
    .rmii_rxd    (rxd),
    .rmii_crs_dv (crs_dv),
    .rmii_rx_er  (rx_er),
    .carrier_o   (carrier),
    .rx_dv_o     (rxdv),
    .byte_o      (bdata),
    .byte_vld_o  (bvld),
    .sof_o       (bsof),
    .eof_o       (beof),
    .byte_err_o  (berr),
    .align_err_o (balign)
  );

  typedef struct {
    logic [DW-1:0] d;
    bit sof;
    bit eof;
    bit err;
    bit al;
  } exp_t;

  exp_t exq[$];
  int   checks = 0;
  int   errors = 0;
  int   edge_cnt = 0;
  int   crs_rise_at = -1, dv_rise_at = -1, crs_fall_at = -1, dv_fall_at = -1;
  logic prev_crs = 1'b0, prev_dv = 1'b0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Monitor: scoreboard pop and edge recording
  always @(negedge clk) begin
    if (!rst) begin
      if (!prev_crs && carrier) crs_rise_at = edge_cnt;
      if (!prev_dv && rxdv)     dv_rise_at  = edge_cnt;
      if (prev_crs && !carrier) crs_fall_at = edge_cnt;
      if (prev_dv && !rxdv)     dv_fall_at  = edge_cnt;
      if (bvld) begin
        exp_t e;
        if (exq.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R10 unexpected byte: actual %0h expected none", bdata);
        end else begin
          e = exq.pop_front();
          chk("R2 R6 R7 byte data", int'(bdata), int'(e.d));
          chk("R8 start flag", int'(bsof), int'(e.sof));
          chk("R8 end flag", int'(beof), int'(e.eof));
          chk("R9 error flag", int'(berr), int'(e.err));
          chk("R10 alignment flag", int'(balign), int'(e.al));
        end
      end
    end
    prev_crs = carrier;
    prev_dv  = rxdv;
  end

  task automatic idle(input int n);
    @(negedge clk);
    rxd    = 2'b00;
    crs_dv = 1'b0;
    rx_er  = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // Slow mode corrupts every cycle outside the middle of the hold period
  task automatic drive_pair(input bit m10, input logic [1:0] d, input logic c,
                            input logic e, output int first);
    @(negedge clk);
    first  = edge_cnt + 1;
    crs_dv = c;
    if (!m10) begin
      rxd   = d;
      rx_er = e;
    end else begin
      for (int k = 0; k < RATIO; k++) begin
        if (k > 0) @(negedge clk);
        rxd   = (k >= 3 && k <= 5) ? d : ~d;
        rx_er = (k >= 3 && k <= 5) ? e : ~e;
      end
    end
  endtask

  task automatic send_frame(input bit m10, input int nbytes, input int extra,
                            input int tail, input int junk_base, input int er_byte,
                            input bit with_sfd, input int seed);
    logic [1:0] dq[$];
    bit         eq[$];
    logic [7:0] pay;
    exp_t       x;
    int body, junk, npairs, nnib, fall_idx, lat, e0, ef, ed;
    e0 = 0; ef = 0; ed = 0;
    body = 8 + nbytes * 4 + extra;
    junk = junk_base + ((junk_base + body) % 2);
    for (int j = 0; j < junk; j++) begin
      dq.push_back((j % 2 == 0) ? 2'b01 : 2'b00);
      eq.push_back(1'b0);
    end
    for (int j = 0; j < 7; j++) begin
      dq.push_back(2'b01);
      eq.push_back(1'b0);
    end
    dq.push_back(with_sfd ? 2'b11 : 2'b01);
    eq.push_back(1'b0);
    for (int b = 0; b < nbytes; b++) begin
      pay = 8'(seed + b * 53);
      for (int p = 0; p < 4; p++) begin
        dq.push_back(pay[2*p +: 2]);
        eq.push_back(b == er_byte && p == 2);
      end
      if (with_sfd) begin
        x.d   = pay;
        x.sof = (b == 0);
        x.eof = (b == nbytes - 1);
        x.err = (b == er_byte);
        x.al  = (b == nbytes - 1) && (extra != 0);
        exq.push_back(x);
      end
    end
    for (int j = 0; j < extra; j++) begin
      dq.push_back(2'b10);
      eq.push_back(1'b0);
    end
    npairs   = dq.size();
    nnib     = npairs / 2;
    fall_idx = (tail > 0) ? 2 * (nnib - tail) : 2 * nnib;
    lat      = m10 ? RATIO / 2 : 1;
    crs_rise_at = -1; dv_rise_at = -1; crs_fall_at = -1; dv_fall_at = -1;
    for (int i = 0; i < npairs + 2; i++) begin
      logic [1:0] d;
      logic       c;
      logic       e;
      int         first;
      d = (i < npairs) ? dq[i] : 2'b00;
      e = (i < npairs) ? eq[i] : 1'b0;
      if (i >= npairs)             c = 1'b0;
      else if (i / 2 < nnib - tail) c = 1'b1;
      else                         c = (i % 2 == 1);
      drive_pair(m10, d, c, e, first);
      if (i == 0)          e0 = first;
      if (i == fall_idx)   ef = first;
      if (i == npairs + 1) ed = first;
    end
    idle(40);
    chk("R3 carrier rise edge", crs_rise_at, e0 + lat);
    chk("R3 data valid rise edge", dv_rise_at, e0 + lat);
    chk("R4 carrier fall edge", crs_fall_at, ef + lat);
    chk("R5 data valid fall edge", dv_fall_at, ed + lat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    chk("R1 carrier after reset", int'(carrier), 0);
    chk("R1 data valid after reset", int'(rxdv), 0);
    chk("R1 byte strobe after reset", int'(bvld), 0);
    chk("R1 end flag after reset", int'(beof), 0);
    chk("R1 alignment flag after reset", int'(balign), 0);
    rst = 1'b0;
    idle(5);

    // Fast rate: delimiter on second di-bit, no toggling tail
    mode_10m = 1'b0;
    send_frame(1'b0, 4, 0, 0, 2, -1, 1'b1, 8'h3c);
    // Fast rate: delimiter on first di-bit, one spare di-bit, two toggle nibbles, error in byte 1
    send_frame(1'b0, 3, 1, 2, 3, 1, 1'b1, 8'ha5);
    // Fast rate: single byte plus two spare di-bits, one toggle nibble
    send_frame(1'b0, 1, 2, 1, 2, -1, 1'b1, 8'h7e);
    // Fast rate: no delimiter, nothing may come out (R6)
    send_frame(1'b0, 0, 0, 1, 4, -1, 1'b0, 8'h00);
    // Fast rate: only a partial byte after the delimiter (R10)
    send_frame(1'b0, 0, 2, 0, 2, -1, 1'b1, 8'h00);
    // Fast rate: longer frame with a long toggling tail
    send_frame(1'b0, 5, 0, 3, 2, 4, 1'b1, 8'h11);

    // Slow rate (R2): corrupted values outside the middle of each hold period
    @(negedge clk); mode_10m = 1'b1;
    idle(5);
    send_frame(1'b1, 3, 0, 1, 2, 0, 1'b1, 8'hc3);
    send_frame(1'b1, 2, 3, 0, 3, -1, 1'b1, 8'h96);

    idle(10);
    chk("R10 every expected byte delivered", exq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule